// File: doc/BRIEF.md
# Cascadable Nine-Tap FIR Filter

This block is a nine-tap finite impulse response filter for one sample stream. The same 12-bit sample is driven on two sample ports in the same cycle. Port A feeds the three earliest taps through a short delay line. Port B feeds a longer delay line that supplies the six later taps. Every tap has its own 10-bit coefficient and its own multiplier. The nine products are added to a 16-bit cascade input that enters partway down the pipeline. The sum is then rounded and clamped into the 16-bit cascade output.

Several instances can be chained for longer kernels. The cascade output of one instance drives the cascade input of the next. A new result leaves the block every clock.

The nine coefficients are held in three sets of three. Each set has one coefficient for each of the groups A, B and C. A 2-bit write code loads a whole set in one cycle from three coefficient buses. The code 00 leaves the whole bank untouched.

Top module: `fir9_casc`

## Requirements
- R1: An asynchronous active-low reset clears the delay lines, the pipeline and all nine coefficients, and drives `casc_out` to 0 while it is asserted. After the reset is released and before any load, every input stream gives an output of 0.
- R2: At a rising edge, write code 01, 10 or 11 copies `coef_a`, `coef_b` and `coef_c` into the group A, B and C coefficients of set 1, 2 or 3 respectively. The other two sets are not changed.
- R3: At a rising edge, write code 00 changes no coefficient, whatever values are on the coefficient buses.
- R4: A sample captured at edge e is weighted by one tap per output. The tap depends on the latency L, where the output appears after edge e+L: L=5 uses A3, L=6 A2, L=7 A1, L=8 B3, L=9 B2, L=10 B1, L=11 C3, L=12 C2 and L=13 C1. Here Gk is the group-G coefficient of set k. A unit impulse therefore returns the nine coefficients in that order, with the centre tap at L=9. Both sample ports must carry the same sample in the same cycle.
- R5: A cascade value captured at edge e is added, at unit weight, to the output that appears after edge e+4.
- R6: The sum is formed as acc = (sum of the nine products) + casc_in·2^SHIFT, with SHIFT=4 by default. The result is floor((acc + 2^(SHIFT-1)) / 2^SHIFT), so a result exactly half way between two codes rounds toward plus infinity.
- R7: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R8: A new output is produced on every clock. Under a continuous random stream, every output equals the reference convolution of R4 to R7.
- R9: Samples, coefficients and cascade words are two's complement: 12, 10 and 16 bits respectively. This includes the extreme values -2048, 2047, -512 and 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_wr | input | 2 | Coefficient write code: 00 hold, 01/10/11 load set 1/2/3 |
| coef_a | input | 10 | Group A coefficient for the set being loaded |
| coef_b | input | 10 | Group B coefficient for the set being loaded |
| coef_c | input | 10 | Group C coefficient for the set being loaded |
| smp_a | input | 12 | Sample port feeding the three early taps |
| smp_b | input | 12 | Sample port feeding the six late taps (same stream as smp_a) |
| casc_in | input | 16 | Cascade word from the previous stage |
| casc_out | output | 16 | Rounded and saturated filter result |

## Verification
The impulse tests check both the order and the exact latency of each tap. A design with the coefficient sets swapped or the delay line off by one stage returns the right values one clock early or late, or in reverse order.

The rounding test uses results that fall exactly half way between two codes, with both signs. Plain truncation would output -28 where -27 is expected, and rounding half away from zero would output -28 as well. Long runs drive the sum to full scale in both directions, so a design that does not saturate shows up as a wrap to the opposite sign.

Garbage is placed on the coefficient buses under the hold code, and only one set is reloaded in another test. These catch designs that write on 00 or that decode the set number wrongly. A reset in the middle of a run, with zero coefficients afterwards, catches a bank that survives reset.

// File: rtl/fir9_casc.sv
module fir9_casc #(
  parameter int XW    = 12,
  parameter int CW    = 10,
  parameter int OW    = 16,
  parameter int SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    coef_wr,
  input  logic [CW-1:0] coef_a,
  input  logic [CW-1:0] coef_b,
  input  logic [CW-1:0] coef_c,
  input  logic [XW-1:0] smp_a,
  input  logic [XW-1:0] smp_b,
  input  logic [OW-1:0] casc_in,
  output logic [OW-1:0] casc_out
);
  localparam int NTAP = 9;
  localparam int NA   = 5;
  localparam int NB   = 11;
  localparam int NC   = 3;
  localparam int PW   = XW + CW;
  localparam int ACCW = PW + 5;
  localparam logic signed [ACCW-1:0] RND  = ACCW'(1 << (SHIFT - 1));
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((1 << (OW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = ~MAXV;

  logic [2:0][2:0][CW-1:0]   kbank;
  logic [XW-1:0]             a_dly [NA];
  logic [XW-1:0]             b_dly [NB];
  logic [OW-1:0]             c_dly [NC];
  logic [NTAP-1:0][XW-1:0]   tapx;
  logic signed [PW-1:0]      prod [NTAP];
  logic signed [ACCW-1:0]    acc_c, acc_q, rnd, shq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kbank <= '0;
    end else begin
      for (int s = 0; s < 3; s++) begin
        if (coef_wr == 2'(s + 1)) begin
          kbank[0][s] <= coef_a;
          kbank[1][s] <= coef_b;
          kbank[2][s] <= coef_c;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) a_dly[i] <= '0;
      for (int i = 0; i < NB; i++) b_dly[i] <= '0;
      for (int i = 0; i < NC; i++) c_dly[i] <= '0;
    end else begin
      a_dly[0] <= smp_a;
      b_dly[0] <= smp_b;
      c_dly[0] <= casc_in;
      for (int i = 1; i < NA; i++) a_dly[i] <= a_dly[i-1];
      for (int i = 1; i < NB; i++) b_dly[i] <= b_dly[i-1];
      for (int i = 1; i < NC; i++) c_dly[i] <= c_dly[i-1];
    end
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    if (i < 3) begin : g_a
      assign tapx[i] = a_dly[2+i];
    end else begin : g_b
      assign tapx[i] = b_dly[2+i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP; i++) prod[i] <= '0;
    end else begin
      for (int i = 0; i < NTAP; i++)
        prod[i] <= $signed({{CW{tapx[i][XW-1]}}, tapx[i]})
                 * $signed({{XW{kbank[i/3][2-(i%3)][CW-1]}}, kbank[i/3][2-(i%3)]});
    end
  end

  always_comb begin
    acc_c = {{(ACCW-OW){c_dly[NC-1][OW-1]}}, c_dly[NC-1]} <<< SHIFT;
    for (int i = 0; i < NTAP; i++)
      acc_c = acc_c + {{(ACCW-PW){prod[i][PW-1]}}, prod[i]};
  end

  assign rnd = acc_q + RND;
  assign shq = rnd >>> SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      casc_out <= '0;
    end else begin
      acc_q    <= acc_c;
      casc_out <= (shq > MAXV) ? MAXV[OW-1:0] :
                  (shq < MINV) ? MINV[OW-1:0] : shq[OW-1:0];
    end
  end
endmodule

// File: rtl/fir9_casc_chk.sv
module fir9_casc_chk #(
  parameter int CW    = 10,
  parameter int OW    = 16,
  parameter int ACCW  = 27,
  parameter int SHIFT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             coef_wr,
  input logic [CW-1:0]          coef_a,
  input logic [CW-1:0]          coef_b,
  input logic [CW-1:0]          coef_c,
  input logic [OW-1:0]          casc_in,
  input logic [OW-1:0]          casc_out,
  input logic [9*CW-1:0]        kflat,
  input logic signed [ACCW-1:0] acc_q
);
  localparam logic signed [ACCW-1:0] HI_T = ACCW'(1) <<< (OW - 1 + SHIFT);
  localparam logic signed [ACCW-1:0] LO_T = -HI_T - (ACCW'(1) <<< SHIFT);
  localparam logic [OW-1:0] OMAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] OMIN = {1'b1, {(OW-1){1'b0}}};

  logic [3:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 4'hf) since_rst <= since_rst + 4'd1;

  a_r1_reset_out: assert property (@(posedge clk) !rst_n |-> casc_out == '0);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr == 2'b00 |=> $stable(kflat));

  a_r2_load_set1: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr == 2'b01 |=> kflat[0*CW +: CW] == $past(coef_a)
                      && kflat[3*CW +: CW] == $past(coef_b)
                      && kflat[6*CW +: CW] == $past(coef_c));

  a_r2_load_set2: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr == 2'b10 |=> kflat[1*CW +: CW] == $past(coef_a)
                      && kflat[4*CW +: CW] == $past(coef_b)
                      && kflat[7*CW +: CW] == $past(coef_c));

  a_r2_load_set3: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr == 2'b11 |=> kflat[2*CW +: CW] == $past(coef_a)
                      && kflat[5*CW +: CW] == $past(coef_b)
                      && kflat[8*CW +: CW] == $past(coef_c));

  a_r5_cascade_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd8 && $past(kflat, 3) == '0) |-> casc_out == $past(casc_in, 5));

  a_r7_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q >= HI_T |=> casc_out == OMAX);

  a_r7_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < LO_T |=> casc_out == OMIN);
endmodule

bind fir9_casc fir9_casc_chk #(.CW(CW), .OW(OW), .ACCW(ACCW), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .coef_wr(coef_wr), .coef_a(coef_a), .coef_b(coef_b),
  .coef_c(coef_c), .casc_in(casc_in), .casc_out(casc_out), .kflat(kbank), .acc_q(acc_q)
);

// File: tb/tb_fir9_casc.sv
module tb_fir9_casc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  coef_wr;
  logic [9:0]  coef_a, coef_b, coef_c;
  logic [11:0] smp_a, smp_b;
  logic [15:0] casc_in;
  logic [15:0] casc_out;

  fir9_casc dut (.clk(clk), .rst_n(rst_n), .coef_wr(coef_wr), .coef_a(coef_a),
    .coef_b(coef_b), .coef_c(coef_c), .smp_a(smp_a), .smp_b(smp_b),
    .casc_in(casc_in), .casc_out(casc_out));

  always #4 clk = ~clk;

  localparam int TN = 20;
  localparam int T_X [TN] = '{16,0,0,0,0, 0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,0};
  localparam int T_C [TN] = '{0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,1000, 0,0,0,0,0};
  localparam int T_E [TN] = '{0,0,0,0,0, 33,-22,11,66,-55, 44,99,-88,77,0, 0,0,0,1000,0};

  int xs [0:4095];
  int cs [0:4095];
  int tapc [9];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s at edge %0d: got %0d expected %0d", req, cyc - 1, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic tick(input int x, input int c);
    smp_a = 12'(x);
    smp_b = 12'(x);
    casc_in = 16'(c);
    xs[cyc] = x;
    cs[cyc] = c;
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) tick(0, 0);
  endtask

  task automatic load(input int sel, input int va, input int vb, input int vc);
    coef_wr = 2'(sel);
    coef_a = 10'(va);
    coef_b = 10'(vb);
    coef_c = 10'(vc);
    tick(0, 0);
    coef_wr = 2'b00;
    tapc[3 - sel] = va;
    tapc[6 - sel] = vb;
    tapc[9 - sel] = vc;
  endtask

  function automatic int model(input int t);
    longint acc = 0;
    for (int i = 0; i < 9; i++)
      if (t - 5 - i >= 0) acc += longint'(tapc[i]) * longint'(xs[t - 5 - i]);
    if (t - 4 >= 0) acc += longint'(cs[t - 4]) * 16;
    acc = (acc + 8) >>> 4;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic int outv();
    return int'($signed(casc_out));
  endfunction

  task automatic walk_table(input string req);
    for (int i = 0; i < TN; i++) begin
      tick(T_X[i], T_C[i]);
      chk(req, outv(), T_E[i]);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    coef_wr = 2'b00;
    coef_a = '0; coef_b = '0; coef_c = '0;
    smp_a = '0; smp_b = '0; casc_in = '0;
    for (int i = 0; i < 9; i++) tapc[i] = 0;
    @(negedge clk);
    chk("R1", outv(), 0);
    flush(3);
    rst_n = 1'b1;
    flush(2);
    chk("R1", outv(), 0);

    load(1, 11, 44, 77);
    load(2, -22, -55, -88);
    load(3, 33, 66, 99);
    flush(16);
    walk_table("R4 R5");

    coef_wr = 2'b00;
    coef_a = 10'h155; coef_b = 10'h2aa; coef_c = 10'h3ff;
    flush(5);
    flush(16);
    walk_table("R3");

    flush(16);
    tick(8, 0);
    for (int k = 1; k <= 10; k++) begin
      tick(0, 0);
      if (k == 5) chk("R6 half up positive", outv(), 17);
      if (k == 7) chk("R6 half up small", outv(), 6);
      if (k == 9) chk("R6 half negative", outv(), -27);
    end

    flush(16);
    for (int k = 0; k < 16; k++) tick(2047, 32767);
    chk("R7 high", outv(), 32767);
    for (int k = 0; k < 16; k++) tick(-2048, -32768);
    chk("R7 low", outv(), -32768);

    flush(16);
    load(2, -100, 200, -300);
    flush(16);
    tick(16, 0);
    for (int k = 1; k <= 14; k++) begin
      tick(0, 0);
      chk("R2", outv(), model(cyc - 1));
    end
    chk("R2 set2 group B", outv(), 0);

    flush(16);
    load(3, -512, 511, -1);
    flush(16);
    tick(-2048, 0);
    for (int k = 1; k <= 14; k++) begin
      tick(2047, 0);
      chk("R9", outv(), model(cyc - 1));
    end
    for (int k = 0; k < 400; k++) begin
      int x = int'($urandom_range(4095)) - 2048;
      int c = (k % 3 == 0) ? int'($urandom_range(65535)) - 32768
                           : int'($urandom_range(4095)) - 2048;
      tick(x, c);
      chk("R8", outv(), model(cyc - 1));
    end

    flush(16);
    load(1, 0, 0, 0);
    load(2, 0, 0, 0);
    load(3, 0, 0, 0);
    flush(16);
    for (int k = 0; k < 30; k++) begin
      tick(int'($urandom_range(4095)) - 2048, int'($urandom_range(65535)) - 32768);
      chk("R5", outv(), model(cyc - 1));
    end

    load(1, 200, -300, 400);
    for (int k = 0; k < 12; k++) tick(int'($urandom_range(4095)) - 2048, 500);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", outv(), 0);
    flush(2);
    rst_n = 1'b1;
    for (int i = 0; i < 9; i++) tapc[i] = 0;
    tick(2047, 0);
    for (int k = 1; k <= 14; k++) begin
      tick(0, 0);
      chk("R1 bank cleared", outv(), 0);
    end

    finish_run();
  end
endmodule